// File: doc/BRIEF.md
# IPv4 Receive Header Filter

This block sits between the receive side of a MAC and a host processor in an end-node network interface. It takes one IPv4 datagram per frame as a byte stream and checks the header on the fly: version, header length, header checksum, total length, TTL, fragmentation fields and destination address. It skips the options area by using the header-length field and passes on only the payload. Padding that the MAC leaves after the datagram's total length is ignored.

Payload bytes are written speculatively into a circular buffer while the frame arrives. At the end of the frame the datagram is either committed, which makes its bytes visible to the host, or dropped. A drop moves the write pointer back to the last commit point, so the host never sees any part of a bad datagram. Drops are silent towards the sender. The only trace is a status field that holds the cause of the most recent drop, together with a one-cycle drop pulse. The host reads committed bytes through a valid/acknowledge handshake, and a last flag marks each datagram's final byte. Routing, fragment reassembly and error replies are not performed.

Top module: `ipv4_rx_filter`

## Requirements
- R1: After reset, `host_valid`, `accept_pulse` and `drop_pulse` are 0 and `drop_cause` is 0 (none).
- R2: A datagram that passes every check is accepted. `accept_pulse` is 1 for the cycle after its last frame byte. Its payload, meaning the bytes from offset 4×IHL up to offset (total length − 1), reaches the host in order, with `host_last` set on the final byte only. Options are skipped. The header fields are laid out as follows: byte 0 carries the version in bits 7:4 and the IHL in bits 3:0. Bytes 2–3 carry the total length, big-endian. Byte 6 carries MF in bit 5 and offset bits 12:8 in bits 4:0. Byte 7 carries offset bits 7:0. Byte 8 carries the TTL, bytes 10–11 the checksum and bytes 16–19 the destination.
- R3: A header whose 16-bit ones'-complement sum over 2×IHL words is not 0xFFFF is dropped with cause 2. A drop raises `drop_pulse` for the cycle after the last frame byte, and `drop_cause` holds its value until the next drop.
- R4: A datagram with TTL equal to zero is dropped with cause 4.
- R5: A version other than 4, or an IHL below 5, gives a drop with cause 1.
- R6: A datagram with MF set or a nonzero fragment offset is dropped with cause 5.
- R7: A destination address different from `local_addr` gives a drop with cause 6.
- R8: A total length smaller than 4×IHL gives a drop with cause 3. A frame that ends before the full header or before the total length has arrived gives a drop with cause 7.
- R9: Bytes after the total length, such as MAC padding, are never delivered.
- R10: If a payload byte arrives while the buffer is full, the datagram is dropped with cause 8 and none of its bytes are delivered. A payload of exactly DEPTH bytes fits into an empty buffer and is delivered.
- R11: No byte of a dropped datagram reaches the host, and data committed earlier is unaffected. A datagram becomes visible to the host only after its last frame byte.
- R12: When several checks fail, the reported cause follows this fixed priority: version/IHL, then checksum, then length, then TTL, then fragment, then address.
- R13: While `host_valid` is 1 and `host_ack` is 0, `host_data` and `host_last` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_addr | input | 32 | IPv4 address of this node |
| rx_valid | input | 1 | A frame byte is present |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Marks the final byte of the frame |
| host_valid | output | 1 | A committed payload byte is available |
| host_data | output | 8 | Payload byte to the host |
| host_last | output | 1 | Final payload byte of a datagram |
| host_ack | input | 1 | Host takes the offered byte |
| accept_pulse | output | 1 | One-cycle pulse when a datagram is committed |
| drop_pulse | output | 1 | One-cycle pulse when a datagram is discarded |
| drop_cause | output | 4 | Cause of the most recent drop |

## Verification
The checks assume the following about the inputs. Every frame ends with exactly one byte that has `rx_last` set. `local_addr` is stable while a frame is in flight. DEPTH is a power of two. The stimulus presents one frame at a time, driving bytes away from the sampling edge with `rx_valid` held high and a single final marker. It keeps `local_addr` constant for the whole run, and it waits for the host side to drain before a new frame starts, so that the check for no early visibility is meaningful. The host acknowledge pattern is pseudo-random, with stretches held low, so that the hold behaviour and a full buffer are both reached.

// File: rtl/ipv4_rx_pkg.sv
package ipv4_rx_pkg;

    typedef enum logic [3:0] {
        DROP_NONE     = 4'd0,
        DROP_VERSION  = 4'd1,
        DROP_CHECKSUM = 4'd2,
        DROP_LENGTH   = 4'd3,
        DROP_TTL      = 4'd4,
        DROP_FRAGMENT = 4'd5,
        DROP_ADDRESS  = 4'd6,
        DROP_SHORT    = 4'd7,
        DROP_OVERFLOW = 4'd8
    } drop_cause_e;

    typedef struct packed {
        logic [15:0] idx;
        logic [15:0] sum;
        logic [7:0]  hi;
        logic [3:0]  ver;
        logic [3:0]  ihl;
        logic [15:0] tot;
        logic        mf;
        logic        frag_nz;
        logic [7:0]  ttl;
        logic [31:0] dst;
        logic        hdr_done;
        drop_cause_e cause;
        logic        ovf;
        logic        accept;
        logic        drop;
        drop_cause_e last_cause;
    } parse_state_t;

    function automatic logic [15:0] ones_add(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'd0, s[16]};
    endfunction

endpackage

// File: rtl/ipv4_hdr_parser.sv
module ipv4_hdr_parser
    import ipv4_rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] local_addr,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    input  logic        buf_full,
    output logic        wr_en,
    output logic [7:0]  wr_data,
    output logic        wr_last,
    output logic        commit,
    output logic        rewind,
    output logic        accept_pulse,
    output logic        drop_pulse,
    output drop_cause_e drop_cause
);

    parse_state_t q, d;
    logic [15:0]  hdr_bytes;
    drop_cause_e  verdict;
    drop_cause_e  final_cause;

    always_comb begin
        hdr_bytes = (q.ihl < 4'd5) ? 16'd20 : {10'd0, q.ihl, 2'b00};
    end

    always_comb begin
        d           = q;
        d.accept    = 1'b0;
        d.drop      = 1'b0;
        wr_en       = 1'b0;
        wr_data     = rx_data;
        wr_last     = 1'b0;
        commit      = 1'b0;
        rewind      = 1'b0;
        verdict     = DROP_NONE;
        final_cause = DROP_NONE;
        if (rx_valid) begin
            if (!q.hdr_done) begin
                case (q.idx)
                    16'd0: begin d.ver = rx_data[7:4]; d.ihl = rx_data[3:0]; end
                    16'd2: d.tot[15:8] = rx_data;
                    16'd3: d.tot[7:0]  = rx_data;
                    16'd6: begin d.mf = rx_data[5]; d.frag_nz = |rx_data[4:0]; end
                    16'd7: d.frag_nz = q.frag_nz | (|rx_data);
                    16'd8: d.ttl = rx_data;
                    default: ;
                endcase
                if (q.idx >= 16'd16 && q.idx <= 16'd19) d.dst = {q.dst[23:0], rx_data};
                if (!q.idx[0]) d.hi = rx_data;
                else           d.sum = ones_add(q.sum, {q.hi, rx_data});
                if (q.idx != 16'd0 && q.idx == hdr_bytes - 16'd1) begin
                    if (d.ver != 4'd4 || d.ihl < 4'd5)  verdict = DROP_VERSION;
                    else if (d.sum != 16'hFFFF)         verdict = DROP_CHECKSUM;
                    else if (d.tot < hdr_bytes)         verdict = DROP_LENGTH;
                    else if (d.ttl == 8'd0)             verdict = DROP_TTL;
                    else if (d.mf || d.frag_nz)         verdict = DROP_FRAGMENT;
                    else if (d.dst != local_addr)       verdict = DROP_ADDRESS;
                    else                                verdict = DROP_NONE;
                    d.hdr_done = 1'b1;
                    d.cause    = verdict;
                end
            end else if (q.cause == DROP_NONE && q.idx < q.tot) begin
                if (buf_full) begin
                    d.ovf = 1'b1;
                end else if (!q.ovf) begin
                    wr_en   = 1'b1;
                    wr_last = (q.idx == q.tot - 16'd1);
                end
            end
            if (q.idx != 16'hFFFF) d.idx = q.idx + 16'd1;
            if (rx_last) begin
                if (!d.hdr_done)                final_cause = DROP_SHORT;
                else if (d.cause != DROP_NONE)  final_cause = d.cause;
                else if (d.ovf)                 final_cause = DROP_OVERFLOW;
                else if (d.idx < q.tot)         final_cause = DROP_SHORT;
                else                            final_cause = DROP_NONE;
                if (final_cause == DROP_NONE) begin
                    commit   = 1'b1;
                    d.accept = 1'b1;
                end else begin
                    rewind       = 1'b1;
                    d.drop       = 1'b1;
                    d.last_cause = final_cause;
                end
                d.idx      = 16'd0;
                d.sum      = 16'd0;
                d.hi       = 8'd0;
                d.ver      = 4'd0;
                d.ihl      = 4'd0;
                d.tot      = 16'd0;
                d.mf       = 1'b0;
                d.frag_nz  = 1'b0;
                d.ttl      = 8'd0;
                d.dst      = 32'd0;
                d.hdr_done = 1'b0;
                d.cause    = DROP_NONE;
                d.ovf      = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign accept_pulse = q.accept;
    assign drop_pulse   = q.drop;
    assign drop_cause   = q.last_cause;

endmodule

// File: rtl/ipv4_rx_buffer.sv
module ipv4_rx_buffer #(
    parameter int DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       wr_last,
    input  logic       commit,
    input  logic       rewind,
    output logic       full,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       rd_last,
    input  logic       rd_ack
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] cm;
        logic [PW-1:0] rd;
    } ptr_t;

    ptr_t q, d;
    logic [8:0] mem [DEPTH];
    logic       do_write;

    assign full     = (q.wr - q.rd) == PW'(DEPTH);
    assign rd_valid = (q.rd != q.cm);
    assign do_write = wr_en && !full && !rewind;
    assign {rd_last, rd_data} = mem[q.rd[AW-1:0]];

    always_comb begin
        d = q;
        if (rd_valid && rd_ack) d.rd = q.rd + PW'(1);
        if (rewind) begin
            d.wr = q.cm;
        end else begin
            if (do_write) d.wr = q.wr + PW'(1);
            if (commit)   d.cm = d.wr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_write) mem[q.wr[AW-1:0]] <= {wr_last, wr_data};
    end

endmodule

// File: rtl/ipv4_rx_filter.sv
module ipv4_rx_filter
    import ipv4_rx_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] local_addr,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    output logic        host_valid,
    output logic [7:0]  host_data,
    output logic        host_last,
    input  logic        host_ack,
    output logic        accept_pulse,
    output logic        drop_pulse,
    output logic [3:0]  drop_cause
);

    logic        wr_en;
    logic [7:0]  wr_data;
    logic        wr_last;
    logic        commit;
    logic        rewind;
    logic        buf_full;
    drop_cause_e cause_w;

    ipv4_hdr_parser u_parser (
        .clk          (clk),
        .rst_n        (rst_n),
        .local_addr   (local_addr),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .rx_last      (rx_last),
        .buf_full     (buf_full),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .wr_last      (wr_last),
        .commit       (commit),
        .rewind       (rewind),
        .accept_pulse (accept_pulse),
        .drop_pulse   (drop_pulse),
        .drop_cause   (cause_w)
    );

    assign drop_cause = cause_w;

    ipv4_rx_buffer #(.DEPTH(DEPTH)) u_buffer (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wr_last  (wr_last),
        .commit   (commit),
        .rewind   (rewind),
        .full     (buf_full),
        .rd_valid (host_valid),
        .rd_data  (host_data),
        .rd_last  (host_last),
        .rd_ack   (host_ack)
    );

endmodule

// File: rtl/ipv4_rx_filter_chk.sv
module ipv4_rx_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       rx_last,
    input logic       wr_en,
    input logic       buf_full,
    input logic       commit,
    input logic       rewind,
    input logic       host_valid,
    input logic [7:0] host_data,
    input logic       host_last,
    input logic       host_ack,
    input logic       accept_pulse,
    input logic       drop_pulse,
    input logic [3:0] drop_cause
);

    AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !buf_full); // R10

    AST_COMMIT_REWIND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && rewind)); // R11

    AST_VERDICT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_pulse || drop_pulse) |-> $past(rx_valid && rx_last)); // R11

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept_pulse && drop_pulse)); // R2

    AST_DROP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse |-> drop_cause != 4'd0); // R3

    AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !drop_pulse |-> $stable(drop_cause)); // R3

    AST_HOST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && !host_ack) |=> (host_valid && $stable(host_data) && $stable(host_last))); // R13

endmodule

bind ipv4_rx_filter ipv4_rx_filter_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .rx_last      (rx_last),
    .wr_en        (wr_en),
    .buf_full     (buf_full),
    .commit       (commit),
    .rewind       (rewind),
    .host_valid   (host_valid),
    .host_data    (host_data),
    .host_last    (host_last),
    .host_ack     (host_ack),
    .accept_pulse (accept_pulse),
    .drop_pulse   (drop_pulse),
    .drop_cause   (drop_cause)
);

// File: tb/tb_ipv4_rx_filter.sv
module tb_ipv4_rx_filter;

    localparam int          DEPTH = 64;
    localparam logic [31:0] LOCAL = 32'hC0A8_0107;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] local_addr;
    logic        rx_valid;
    logic [7:0]  rx_data;
    logic        rx_last;
    logic        host_valid;
    logic [7:0]  host_data;
    logic        host_last;
    logic        host_ack;
    logic        accept_pulse;
    logic        drop_pulse;
    logic [3:0]  drop_cause;

    int         checks = 0;
    int         errors = 0;
    bit         ack_en = 1'b1;
    bit         done = 1'b0;
    logic [8:0] exp_q[$];
    logic [7:0] fr[$];

    always #10 clk = ~clk;

    ipv4_rx_filter #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .local_addr(local_addr),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .host_valid(host_valid), .host_data(host_data), .host_last(host_last),
        .host_ack(host_ack), .accept_pulse(accept_pulse),
        .drop_pulse(drop_pulse), .drop_cause(drop_cause)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: decide acknowledge, then pop and compare the byte taken at the next edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            host_ack = 1'b0;
        end else begin
            host_ack = ack_en && ($urandom_range(0, 3) != 0);
            if (host_valid && host_ack) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11", "unexpected host byte", {23'd0, host_last, host_data}, 0);
                end else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    check({host_last, host_data} == e, "R2", "payload byte",
                          {23'd0, host_last, host_data}, {23'd0, e});
                end
            end
        end
    end

    // Build a frame in fr; push the payload as expected when good is set.
    task automatic build(input int ver, input int ihl, input int ttl, input bit mf,
                         input int foff, input logic [31:0] dst, input int paylen,
                         input int pad, input bit bad_csum, input int tot_ovr,
                         input int seed, input bit good);
        int          hn;
        int          tot;
        int          s;
        logic [15:0] cs;
        hn  = (ihl < 5) ? 20 : ihl * 4;
        tot = (tot_ovr >= 0) ? tot_ovr : hn + paylen;
        fr.delete();
        for (int i = 0; i < hn; i++) fr.push_back(8'h01);
        fr[0]  = {ver[3:0], ihl[3:0]};
        fr[1]  = 8'h00;
        fr[2]  = tot[15:8];
        fr[3]  = tot[7:0];
        fr[4]  = 8'h12;
        fr[5]  = seed[7:0];
        fr[6]  = {2'b01, mf, foff[12:8]};
        fr[7]  = foff[7:0];
        fr[8]  = ttl[7:0];
        fr[9]  = 8'd17;
        fr[10] = 8'h00;
        fr[11] = 8'h00;
        fr[12] = 8'h0A; fr[13] = 8'h00; fr[14] = 8'h00; fr[15] = 8'h01;
        fr[16] = dst[31:24]; fr[17] = dst[23:16]; fr[18] = dst[15:8]; fr[19] = dst[7:0];
        s = 0;
        for (int i = 0; i < hn; i += 2) begin
            s = s + {16'd0, fr[i], fr[i+1]};
            s = (s & 32'hFFFF) + (s >>> 16);
        end
        cs = ~s[15:0];
        if (bad_csum) cs = cs ^ 16'h0001;
        fr[10] = cs[15:8];
        fr[11] = cs[7:0];
        for (int i = 0; i < paylen; i++) begin
            logic [7:0] b;
            b = 8'((seed * 7 + i * 3) & 255);
            fr.push_back(b);
            if (good) exp_q.push_back({(i == paylen - 1), b});
        end
        for (int i = 0; i < pad; i++) fr.push_back(8'h00);
    endtask

    task automatic drain();
        for (int i = 0; i < 3000; i++) begin
            if (exp_q.size() == 0 && !host_valid) break;
            @(negedge clk);
        end
    endtask

    // Driver: send fr (optionally truncated) and check the verdict.
    task automatic send(input int cause_exp, input int trunc, input string req);
        int n;
        drain();
        n = (trunc >= 0) ? trunc : fr.size();
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = fr[i];
            rx_last  = (i == n - 1);
            if (i == n - 1)
                check(host_valid == 1'b0, "R11", "visible before frame end", host_valid, 0);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last  = 1'b0;
        if (cause_exp == 0) begin
            check(accept_pulse && !drop_pulse, req, "accept pulse",
                  {accept_pulse, drop_pulse}, 2'b10);
        end else begin
            check(drop_pulse && !accept_pulse, req, "drop pulse",
                  {accept_pulse, drop_pulse}, 2'b01);
            check(drop_cause == 4'(cause_exp), req, "drop cause", drop_cause, cause_exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; local_addr = LOCAL;
        rx_valid = 1'b0; rx_data = 8'h00; rx_last = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!host_valid, "R1", "host_valid", host_valid, 0);
        check(!accept_pulse && !drop_pulse, "R1", "pulses", {accept_pulse, drop_pulse}, 0);
        check(drop_cause == 4'd0, "R1", "drop_cause", drop_cause, 0);

        // R2 good datagrams, with and without options, and with no payload
        build(4, 5, 64, 0, 0, LOCAL, 8, 0, 0, -1, 1, 1);   send(0, -1, "R2");
        build(4, 7, 1, 0, 0, LOCAL, 5, 0, 0, -1, 2, 1);    send(0, -1, "R2");
        build(4, 15, 9, 0, 0, LOCAL, 12, 0, 0, -1, 3, 1);  send(0, -1, "R2");
        build(4, 5, 9, 0, 0, LOCAL, 0, 0, 0, -1, 4, 1);    send(0, -1, "R2");
        // R3 checksum
        build(4, 6, 64, 0, 0, LOCAL, 6, 0, 1, -1, 5, 0);   send(2, -1, "R3");
        // R4 TTL zero
        build(4, 5, 0, 0, 0, LOCAL, 6, 0, 0, -1, 6, 0);    send(4, -1, "R4");
        // R5 version and IHL
        build(6, 5, 64, 0, 0, LOCAL, 6, 0, 0, -1, 7, 0);   send(1, -1, "R5");
        build(4, 4, 64, 0, 0, LOCAL, 6, 0, 0, -1, 8, 0);   send(1, -1, "R5");
        // R6 fragments
        build(4, 5, 64, 1, 0, LOCAL, 6, 0, 0, -1, 9, 0);   send(5, -1, "R6");
        build(4, 5, 64, 0, 3, LOCAL, 6, 0, 0, -1, 10, 0);  send(5, -1, "R6");
        build(4, 5, 64, 0, 256, LOCAL, 6, 0, 0, -1, 11, 0); send(5, -1, "R6");
        // R7 address
        build(4, 5, 64, 0, 0, LOCAL ^ 32'h1, 6, 0, 0, -1, 12, 0); send(6, -1, "R7");
        // R8 bad length and short frames
        build(4, 5, 64, 0, 0, LOCAL, 6, 0, 0, 12, 13, 0);  send(3, -1, "R8");
        build(4, 5, 64, 0, 0, LOCAL, 10, 0, 0, -1, 14, 0); send(7, 25, "R8");
        build(4, 5, 64, 0, 0, LOCAL, 10, 0, 0, -1, 15, 0); send(7, 10, "R8");
        // R11 a good datagram right after drops
        build(4, 5, 32, 0, 0, LOCAL, 9, 0, 0, -1, 16, 1);  send(0, -1, "R11");
        // R9 padding after total length
        build(4, 5, 64, 0, 0, LOCAL, 3, 20, 0, -1, 17, 1); send(0, -1, "R9");
        // R12 priority
        build(5, 5, 64, 0, 0, LOCAL, 4, 0, 1, -1, 18, 0);  send(1, -1, "R12");
        build(4, 5, 0, 0, 0, LOCAL ^ 32'h100, 4, 0, 0, -1, 19, 0); send(4, -1, "R12");
        build(4, 5, 64, 1, 0, LOCAL ^ 32'h100, 4, 0, 0, -1, 20, 0); send(5, -1, "R12");
        // R10 overflow then exact fit, host stalled
        drain();
        ack_en = 1'b0;
        build(4, 5, 64, 0, 0, LOCAL, DEPTH + 6, 0, 0, -1, 21, 0); send(8, -1, "R10");
        check(!host_valid, "R10", "nothing visible after overflow", host_valid, 0);
        build(4, 5, 64, 0, 0, LOCAL, DEPTH, 0, 0, -1, 22, 1);
        begin
            int n;
            n = fr.size();
            for (int i = 0; i < n; i++) begin
                @(negedge clk);
                rx_valid = 1'b1; rx_data = fr[i]; rx_last = (i == n - 1);
            end
            @(negedge clk);
            rx_valid = 1'b0; rx_last = 1'b0;
            check(accept_pulse, "R10", "exact fit accepted", accept_pulse, 1);
        end
        // R13 hold while not acknowledged
        begin
            logic [8:0] first;
            first = {host_last, host_data};
            repeat (5) @(negedge clk);
            check({host_last, host_data} == first && host_valid, "R13", "held byte",
                  {23'd0, host_last, host_data}, {23'd0, first});
            check(first == exp_q[0], "R13", "held byte value", {23'd0, first}, {23'd0, exp_q[0]});
        end
        ack_en = 1'b1;
        drain();
        check(exp_q.size() == 0, "R11", "all expected bytes delivered", exp_q.size(), 0);
        repeat (4) @(negedge clk);
        check(!host_valid, "R9", "no extra bytes", host_valid, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule